// File: doc/BRIEF.md
# Interrupt Priority Recognition Unit

This block gathers every kind of request that can interrupt the processor's instruction stream and picks at most one to take per cycle. There are nine request classes. Four external lines (cache flush, system-management interrupt, init, NMI) act on their rising edges. They pass through a synchronizer and stay latched as pending until they are granted. Four lines (bus-check, run/stop, maskable INTR, stop-clock) are sampled live as levels and are never latched. A software exception request can be taken in any cycle.

External requests are recognized only at an instruction retirement boundary. If a bus cycle is in progress, the boundary also needs the write buffer to be empty. The boundary right after an instruction that loaded the stack segment is skipped, so the next instruction retires before anything is taken. A small state machine tracks the boundary: `ST_IDLE` is between boundaries. `ST_SHADOW` follows a stack-segment load. `ST_DRAIN` holds a boundary open while the write buffer empties. The transitions are:
- idle/shadow to shadow on a stack-segment retire;
- idle/shadow to drain on a retire when a request is eligible but the write buffer is not ready;
- idle/shadow to idle on any other retire;
- drain to idle once the write buffer is ready, or once no request remains eligible.

A granted system-management interrupt enters SMM mode. In that mode, further SMI, INIT and NMI requests are held back and stay pending. The grant appears one cycle after the decision as a one-hot vector with a valid strobe, a 16-bit vector or entry code, and the kind of acknowledge cycle to run.

Top module: `intr_recog`

## Requirements
- R1: Fixed priority from highest to lowest, with grant bit index: exception (0), bus-check (1), run/stop (2), flush (3), SMI (4), INIT (5), NMI (6), INTR (7), stop-clock (8). Only the highest eligible request is granted.
- R2: `grant_vld` rises in the cycle after a decision, and `grant` is then one-hot. When `grant_vld` is low, `grant` is all zero.
- R3: A rising edge on flush, SMI, INIT or NMI, seen through a two-stage synchronizer, latches a pending request. Granting it clears it. A pending request that is not granted survives to later boundaries.
- R4: Bus-check, run/stop, INTR and stop-clock are not latched. A level that drops before the boundary is never granted.
- R5: `exc_req` is granted in any cycle, with no boundary needed. Its code is `exc_vec` zero-extended.
- R6: The eight external classes are granted only on a cycle with `retire` high, or while a held-open boundary is waiting for the write buffer.
- R7: When `bus_busy` is high and `wb_empty` is low at a boundary, no external grant is made. The boundary stays open, ignoring further `retire` pulses, and grants in the cycle after the write buffer becomes ready.
- R8: A `retire` with `ss_load` high grants no external request. The next `retire` without `ss_load` does.
- R9: Granting SMI sets `smm_mode`. While `smm_mode` is high, SMI, INIT and NMI are not granted but stay pending. The other classes are still granted.
- R10: `smm_exit` clears `smm_mode` on the following clock edge. After that, held SMI, INIT or NMI requests become eligible again.
- R11: Bus-check is eligible only when `mce_en` is 1, and it reports code 18. NMI reports code 2.
- R12: INTR is eligible only when `if_flag` is 1. With `if_flag` low, stop-clock can still be granted.
- R13: Codes and acknowledge kinds are as follows. SMI reports code 8000h. The acknowledge kind is 1 for INTR (code 0), 2 for flush and 3 for stop-clock. Every other grant uses acknowledge kind 0, and uses code 0 unless R5 or R11 gives one.
- R14: After reset, `grant_vld`, `grant`, `grant_code`, `ack_kind` and `smm_mode` are all zero and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Software exception request |
| exc_vec | input | 8 | Exception vector |
| bus_check | input | 1 | Bus-check level request |
| run_stop | input | 1 | Run/stop level request |
| flush_req | input | 1 | Cache flush edge request |
| smi_req | input | 1 | System-management interrupt edge request |
| init_req | input | 1 | Init edge request |
| nmi_req | input | 1 | Non-maskable interrupt edge request |
| intr_req | input | 1 | Maskable interrupt level request |
| stop_clk | input | 1 | Stop-clock level request |
| mce_en | input | 1 | Machine-check enable control bit |
| if_flag | input | 1 | Interrupt-enable flag |
| retire | input | 1 | Instruction retirement boundary strobe |
| ss_load | input | 1 | Retiring instruction loaded the stack segment |
| bus_busy | input | 1 | Bus cycle in progress |
| wb_empty | input | 1 | Write buffer empty |
| smm_exit | input | 1 | Leave SMM mode |
| grant_vld | output | 1 | Grant strobe |
| grant | output | 9 | One-hot grant, bit index per R1 |
| grant_code | output | 16 | Vector or entry code |
| ack_kind | output | 2 | Acknowledge cycle: 0 none, 1 interrupt-acknowledge, 2 flush-acknowledge, 3 stop-grant |
| smm_mode | output | 1 | SMM mode active |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 16-bit code and an 8-bit exception vector. With these, the whole request space is small enough to sweep. It covers all 64 combinations of the four level lines together with `mce_en` and `if_flag` at one boundary. It also latches all 16 subsets of the four edge lines and retires repeatedly until every one has drained, which includes the SMM hold-back and release. Directed sequences add the drain wait, the stack-segment shadow, exceptions both off and on a boundary, and a level that drops before the boundary.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int NSRC       = 9;
    localparam int SRC_EXC    = 0;
    localparam int SRC_BCHK   = 1;
    localparam int SRC_RS     = 2;
    localparam int SRC_FLUSH  = 3;
    localparam int SRC_SMI    = 4;
    localparam int SRC_INIT   = 5;
    localparam int SRC_NMI    = 6;
    localparam int SRC_INTR   = 7;
    localparam int SRC_STPCLK = 8;
    localparam int EDGE_BASE  = SRC_FLUSH;
    localparam int N_EDGE     = 4;

    typedef enum logic [1:0] {
        ACK_NONE    = 2'd0,
        ACK_INTA    = 2'd1,
        ACK_FLUSH   = 2'd2,
        ACK_STOPGNT = 2'd3
    } ack_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHADOW = 2'd1,
        ST_DRAIN  = 2'd2
    } bnd_state_e;
endpackage

// File: rtl/edge_pend.sv
module edge_pend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic pend
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
            pend   <= (pend & ~clr) | rise;
        end
    end

    // R3
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise) |=> !pend);

    // R3
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pend);
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N = 9
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic taken;

    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/intr_recog.sv
module intr_recog
    import intr_pkg::*;
#(
    parameter int CODE_W      = 16,
    parameter int EXC_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SMI_OFFSET  = 32'h8000,
    parameter int BCHK_VEC    = 18,
    parameter int NMI_VEC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [EXC_W-1:0]  exc_vec,
    input  logic              bus_check,
    input  logic              run_stop,
    input  logic              flush_req,
    input  logic              smi_req,
    input  logic              init_req,
    input  logic              nmi_req,
    input  logic              intr_req,
    input  logic              stop_clk,
    input  logic              mce_en,
    input  logic              if_flag,
    input  logic              retire,
    input  logic              ss_load,
    input  logic              bus_busy,
    input  logic              wb_empty,
    input  logic              smm_exit,
    output logic              grant_vld,
    output logic [NSRC-1:0]   grant,
    output logic [CODE_W-1:0] grant_code,
    output logic [1:0]        ack_kind,
    output logic              smm_mode
);
    localparam logic [CODE_W-1:0] SMI_CODE  = CODE_W'(SMI_OFFSET);
    localparam logic [CODE_W-1:0] BCHK_CODE = CODE_W'(BCHK_VEC);
    localparam logic [CODE_W-1:0] NMI_CODE  = CODE_W'(NMI_VEC);

    bnd_state_e          state, nxt;
    logic [N_EDGE-1:0]   edge_pin, pend;
    logic [NSRC-1:1]     ext_elig;
    logic [NSRC-1:0]     req, sel;
    logic                wb_ok, ext_any, open_bnd;
    logic [CODE_W-1:0]   code_d;
    ack_e                ack_d;

    // ---- edge-triggered sources: synchronize, detect, hold pending ----
    assign edge_pin = {nmi_req, init_req, smi_req, flush_req};

    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        edge_pend #(.SYNC_STAGES(SYNC_STAGES)) u_pend (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (edge_pin[g]),
            .clr  (sel[EDGE_BASE+g]),
            .pend (pend[g])
        );
    end

    // ---- eligibility ----
    assign wb_ok = !bus_busy || wb_empty;

    always_comb begin
        ext_elig[SRC_BCHK]   = bus_check & mce_en;
        ext_elig[SRC_RS]     = run_stop;
        ext_elig[SRC_FLUSH]  = pend[SRC_FLUSH-EDGE_BASE];
        ext_elig[SRC_SMI]    = pend[SRC_SMI-EDGE_BASE]  & ~smm_mode;
        ext_elig[SRC_INIT]   = pend[SRC_INIT-EDGE_BASE] & ~smm_mode;
        ext_elig[SRC_NMI]    = pend[SRC_NMI-EDGE_BASE]  & ~smm_mode;
        ext_elig[SRC_INTR]   = intr_req & if_flag;
        ext_elig[SRC_STPCLK] = stop_clk;
    end

    assign ext_any  = |ext_elig;
    assign open_bnd = wb_ok &&
                      ((state == ST_DRAIN) || (retire && !ss_load));
    assign req      = {ext_elig & {(NSRC-1){open_bnd}}, exc_req};

    prio_pick #(.N(NSRC)) u_pick (
        .req(req),
        .gnt(sel)
    );

    // ---- boundary state machine: next state ----
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_SHADOW: begin
                if (retire) begin
                    if (ss_load)
                        nxt = ST_SHADOW;
                    else if (ext_any && !wb_ok)
                        nxt = ST_DRAIN;
                    else
                        nxt = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (!ext_any)
                    nxt = ST_IDLE;
                else if (wb_ok && !sel[SRC_EXC])
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // ---- grant decode ----
    always_comb begin
        code_d = '0;
        ack_d  = ACK_NONE;
        if (sel[SRC_EXC])    code_d = CODE_W'(exc_vec);
        if (sel[SRC_BCHK])   code_d = BCHK_CODE;
        if (sel[SRC_FLUSH])  ack_d  = ACK_FLUSH;
        if (sel[SRC_SMI])    code_d = SMI_CODE;
        if (sel[SRC_NMI])    code_d = NMI_CODE;
        if (sel[SRC_INTR])   ack_d  = ACK_INTA;
        if (sel[SRC_STPCLK]) ack_d  = ACK_STOPGNT;
    end

    // ---- output and mode register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_vld  <= 1'b0;
            grant      <= '0;
            grant_code <= '0;
            ack_kind   <= ACK_NONE;
            smm_mode   <= 1'b0;
        end else begin
            grant_vld  <= |sel;
            grant      <= sel;
            grant_code <= code_d;
            ack_kind   <= ack_d;
            if (smm_exit)
                smm_mode <= 1'b0;
            else if (sel[SRC_SMI])
                smm_mode <= 1'b1;
        end
    end

    // ---- assertions ----
    // R2
    onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> ($countones(grant) == 1));

    // R2
    idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld |-> (grant == '0));

    // R6
    ext_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !grant[SRC_EXC]) |-> ($past(retire) || $past(state) == ST_DRAIN));

    // R7
    wb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !grant[SRC_EXC]) |-> (!$past(bus_busy) || $past(wb_empty)));

    // R8
    ss_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !grant[SRC_EXC]) |-> !$past(retire && ss_load && state != ST_DRAIN));

    // R9
    smm_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(smm_mode) |-> !(grant[SRC_SMI] || grant[SRC_INIT] || grant[SRC_NMI]));

    // R10
    smm_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_mode && smm_exit) |=> !smm_mode);

    // R11
    bchk_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant[SRC_BCHK] |-> ($past(mce_en) && grant_code == BCHK_CODE));
endmodule

// File: tb/intr_recog_tb.sv
module intr_recog_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exc_req = 0; logic [7:0] exc_vec = 0;
    logic bus_check = 0, run_stop = 0, flush_req = 0, smi_req = 0;
    logic init_req = 0, nmi_req = 0, intr_req = 0, stop_clk = 0;
    logic mce_en = 0, if_flag = 0, retire = 0, ss_load = 0;
    logic bus_busy = 0, wb_empty = 0, smm_exit = 0;
    logic grant_vld; logic [8:0] grant; logic [15:0] grant_code;
    logic [1:0] ack_kind; logic smm_mode;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    intr_recog u_dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_vec(exc_vec),
        .bus_check(bus_check), .run_stop(run_stop), .flush_req(flush_req),
        .smi_req(smi_req), .init_req(init_req), .nmi_req(nmi_req),
        .intr_req(intr_req), .stop_clk(stop_clk), .mce_en(mce_en),
        .if_flag(if_flag), .retire(retire), .ss_load(ss_load),
        .bus_busy(bus_busy), .wb_empty(wb_empty), .smm_exit(smm_exit),
        .grant_vld(grant_vld), .grant(grant), .grant_code(grant_code),
        .ack_kind(ack_kind), .smm_mode(smm_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // expected {vld, grant[8:0], code[15:0], ack[1:0]} for source index (-1 = none)
    function automatic logic [27:0] exp_out(input int idx, input logic [7:0] ev);
        logic [8:0] g; logic [15:0] c; logic [1:0] a;
        g = '0; c = '0; a = 2'd0;
        if (idx < 0) return 28'd0;
        g[idx] = 1'b1;
        case (idx)
            0: c = {8'h00, ev};
            1: c = 16'd18;
            3: a = 2'd2;
            4: c = 16'h8000;
            6: c = 16'd2;
            7: a = 2'd1;
            8: a = 2'd3;
            default: ;
        endcase
        return {1'b1, g, c, a};
    endfunction

    function automatic int first_set(input logic [8:0] v);
        for (int i = 0; i < 9; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic check_grant(input string tag, input int idx, input logic [7:0] ev);
        check(tag, {4'd0, grant_vld, grant, grant_code, ack_kind}, {4'd0, exp_out(idx, ev)});
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic boundary(input logic ss);
        @(negedge clk); retire = 1; ss_load = ss;
        @(negedge clk); retire = 0; ss_load = 0;
    endtask

    task automatic pulse_edges(input logic [3:0] s);
        @(negedge clk);
        {nmi_req, init_req, smi_req, flush_req} = s;
        repeat (4) @(negedge clk);
        {nmi_req, init_req, smi_req, flush_req} = 4'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic leave_smm();
        @(negedge clk); smm_exit = 1;
        @(negedge clk); smm_exit = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R14: reset state
        check("R14", {grant_vld, grant, grant_code, ack_kind, smm_mode}, 0);

        // R1 R11 R12 R13: all level combinations with mce_en and if_flag
        for (int v = 0; v < 64; v++) begin
            logic [8:0] el;
            @(negedge clk);
            {bus_check, run_stop, intr_req, stop_clk, mce_en, if_flag} = v[5:0];
            el = '0;
            el[1] = bus_check & mce_en;
            el[2] = run_stop;
            el[7] = intr_req & if_flag;
            el[8] = stop_clk;
            boundary(0);
            check_grant("R1", first_set(el), 8'h00);
            @(negedge clk);
            {bus_check, run_stop, intr_req, stop_clk, mce_en, if_flag} = 6'b0;
        end

        // R12: if_flag low, INTR ignored, stop-clock taken
        @(negedge clk); intr_req = 1; stop_clk = 1; if_flag = 0;
        boundary(0);
        check_grant("R12", 8, 8'h00);
        @(negedge clk); intr_req = 0; stop_clk = 0;

        // R11: bus-check masked without mce_en
        @(negedge clk); bus_check = 1; mce_en = 0;
        boundary(0);
        check_grant("R11", -1, 8'h00);
        @(negedge clk); bus_check = 0;

        // R3 R9 R10 R13: every subset of edge sources drained in order
        for (int s = 0; s < 16; s++) begin
            logic [3:0] p; logic smm;
            do_reset();
            pulse_edges(s[3:0]);
            p = s[3:0]; smm = 0;
            for (int step = 0; step < 8; step++) begin
                logic [8:0] el; int idx;
                el = '0;
                el[3] = p[0];
                el[4] = p[1] & !smm;
                el[5] = p[2] & !smm;
                el[6] = p[3] & !smm;
                idx = first_set(el);
                boundary(0);
                check_grant("R3", idx, 8'h00);
                if (idx >= 3) p[idx-3] = 1'b0;
                if (idx == 4) smm = 1;
                check("R9", {31'd0, smm_mode}, {31'd0, smm});
                if (idx < 0 && smm) begin
                    leave_smm();
                    smm = 0;
                    check("R10", {31'd0, smm_mode}, 32'd0);
                end
            end
        end

        // R9: in SMM, NMI held but stop-clock still taken; released after exit
        do_reset();
        pulse_edges(4'b0010);
        boundary(0);
        check_grant("R9", 4, 8'h00);
        pulse_edges(4'b1000);
        @(negedge clk); stop_clk = 1;
        boundary(0);
        check_grant("R9", 8, 8'h00);
        @(negedge clk); stop_clk = 0;
        boundary(0);
        check_grant("R9", -1, 8'h00);
        leave_smm();
        check("R10", {31'd0, smm_mode}, 32'd0);
        boundary(0);
        check_grant("R10", 6, 8'h00);

        // R4: level dropped before boundary is lost
        @(negedge clk); intr_req = 1; if_flag = 1;
        repeat (3) @(negedge clk);
        intr_req = 0;
        boundary(0);
        check_grant("R4", -1, 8'h00);

        // R6: level present, no retire -> nothing
        @(negedge clk); intr_req = 1;
        repeat (3) @(negedge clk);
        check_grant("R6", -1, 8'h00);

        // R5: exception off-boundary
        @(negedge clk); exc_req = 1; exc_vec = 8'h0E;
        @(negedge clk); exc_req = 0;
        check_grant("R5", 0, 8'h0E);
        @(negedge clk); intr_req = 0;

        // R1 R3 R5: exception beats pending NMI at a boundary, NMI kept
        pulse_edges(4'b1000);
        @(negedge clk); exc_req = 1; exc_vec = 8'h06; retire = 1;
        @(negedge clk); exc_req = 0; retire = 0;
        check_grant("R5", 0, 8'h06);
        boundary(0);
        check_grant("R3", 6, 8'h00);

        // R8: stack-segment shadow
        @(negedge clk); intr_req = 1; if_flag = 1;
        boundary(1);
        check_grant("R8", -1, 8'h00);
        boundary(0);
        check_grant("R8", 7, 8'h00);
        @(negedge clk); intr_req = 0;

        // R7: write-buffer drain wait, retire ignored while waiting
        @(negedge clk); intr_req = 1; bus_busy = 1; wb_empty = 0;
        boundary(0);
        check_grant("R7", -1, 8'h00);
        boundary(0);
        check_grant("R7", -1, 8'h00);
        repeat (2) @(negedge clk);
        check_grant("R7", -1, 8'h00);
        wb_empty = 1;
        @(negedge clk);
        check_grant("R7", 7, 8'h00);
        intr_req = 0; bus_busy = 0; wb_empty = 0;
        @(negedge clk);
        check_grant("R2", -1, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule